// File: doc/BRIEF.md
# Alternating Read/Write Slot Arbiter

This block grants a single transaction slot per clock to one of two requesters: a read port and a write port of a memory whose array can start only one access per cycle. On every rising clock edge it samples an active-low select from each port. It then raises a one-cycle issue strobe for at most one of them toward the downstream array controller. A registered record of the operation just issued is kept and presented as an output.

When both ports ask in the same cycle, the winner depends on the previous cycle's operation. After an idle cycle the read wins. After a read the write wins, and after a write the read wins. As a result, two reads never start on consecutive cycles, and neither do two writes. A port asking alone is held back for one cycle if it was the one served last. Address and data paths, bursts and the array itself belong to other blocks.

Top module: `rw_slot_arbiter`

## Requirements
- R1: In any cycle at most one of `rd_issue` and `wr_issue` is high.
- R2: The selects are active low and are sampled only at the rising clock edge. A strobe appears in the cycle after the sampling edge and holds for that whole cycle, even if the selects change. A select pulse that lies entirely between two edges has no effect.
- R3: With both selects active and a previous record of idle, the read is issued.
- R4: With both selects active and a previous record of read, the write is issued.
- R5: With both selects active and a previous record of write, the read is issued.
- R6: Holding both selects active from an idle record issues read, write, read, write, and so on, strictly alternating.
- R7: A port selected alone issues when the previous record is idle or the other operation. The other port being deselected does not affect it.
- R8: A port selected alone whose own operation is the previous record issues nothing for that cycle. The record becomes idle, and the port issues on the following cycle if it is still selected.
- R9: With neither select active, nothing is issued and the record becomes idle.
- R10: `last_op` encodes idle as 2'b00, read as 2'b01 and write as 2'b10, and always names the operation whose strobe is high in the same cycle.
- R11: A synchronous active-high `rst` sampled at an edge forces `last_op` to idle and both strobes low for the next cycle, whatever the selects are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; selects are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel_n | input | 1 | Read-port select, active low |
| wr_sel_n | input | 1 | Write-port select, active low |
| rd_issue | output | 1 | One-cycle read issue strobe |
| wr_issue | output | 1 | One-cycle write issue strobe |
| last_op | output | 2 | Registered record of the operation just issued |

## Verification
The bench builds each of the three previous-record states and then applies all four select combinations to it. This exposes a fixed-priority design, which would issue a read after a read, and a round-robin design that remembers the last winner across idle cycles instead of resetting to read-first. A lone port that issues on consecutive cycles shows that the stall rule of R8 is missing. A design that never clears the record would keep the port blocked indefinitely. A select pulse placed between edges catches a design that reacts combinationally or to the falling edge. Reset is applied with both selects active, which catches a reset that leaks a strobe.

// File: rtl/rwarb_pkg.sv
package rwarb_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_RD   = 2'b01,
      OP_WR   = 2'b10
   } op_t;
endpackage

// File: rtl/sel_normalize.sv
module sel_normalize #(
   parameter int ACTIVE_LOW = 1
) (
   input  logic rd_sel_raw,
   input  logic wr_sel_raw,
   output logic rd_req,
   output logic wr_req
);
   generate
      if (ACTIVE_LOW != 0 && ACTIVE_LOW != 1) begin : g_bad
         $error("sel_normalize: ACTIVE_LOW must be 0 or 1");
      end
      if (ACTIVE_LOW == 1) begin : g_low
         assign rd_req = ~rd_sel_raw;
         assign wr_req = ~wr_sel_raw;
      end else begin : g_high
         assign rd_req = rd_sel_raw;
         assign wr_req = wr_sel_raw;
      end
   endgenerate
endmodule

// File: rtl/slot_decide.sv
module slot_decide
   import rwarb_pkg::*;
(
   input  logic rd_req,
   input  logic wr_req,
   input  op_t  prev_op,
   output op_t  next_op
);
   always_comb begin
      next_op = OP_IDLE;
      unique case ({rd_req, wr_req})
         2'b11:   next_op = (prev_op == OP_RD) ? OP_WR : OP_RD;
         2'b10:   next_op = (prev_op == OP_RD) ? OP_IDLE : OP_RD;
         2'b01:   next_op = (prev_op == OP_WR) ? OP_IDLE : OP_WR;
         default: next_op = OP_IDLE;
      endcase
   end
endmodule

// File: rtl/op_history.sv
module op_history
   import rwarb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  op_t  next_op,
   output op_t  last_op,
   output logic rd_issue,
   output logic wr_issue
);
   always_ff @(posedge clk) begin
      if (rst) begin
         last_op  <= OP_IDLE;
         rd_issue <= 1'b0;
         wr_issue <= 1'b0;
      end else begin
         last_op  <= next_op;
         rd_issue <= (next_op == OP_RD);
         wr_issue <= (next_op == OP_WR);
      end
   end

   // R1
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd_issue, wr_issue}));

   // R8
   no_rd_twice_chk: assert property (@(posedge clk) disable iff (rst)
      rd_issue |=> !rd_issue);

   // R8
   no_wr_twice_chk: assert property (@(posedge clk) disable iff (rst)
      wr_issue |=> !wr_issue);

   // R11
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (last_op == OP_IDLE && !rd_issue && !wr_issue));
endmodule

// File: rtl/rw_slot_arbiter.sv
module rw_slot_arbiter
   import rwarb_pkg::*;
#(
   parameter int SEL_ACTIVE_LOW = 1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rd_sel_n,
   input  logic       wr_sel_n,
   output logic       rd_issue,
   output logic       wr_issue,
   output logic [1:0] last_op
);
   logic rd_req, wr_req;
   op_t  next_op, hist_op;

   sel_normalize #(.ACTIVE_LOW(SEL_ACTIVE_LOW)) u_norm (
      .rd_sel_raw (rd_sel_n),
      .wr_sel_raw (wr_sel_n),
      .rd_req     (rd_req),
      .wr_req     (wr_req)
   );

   slot_decide u_decide (
      .rd_req  (rd_req),
      .wr_req  (wr_req),
      .prev_op (hist_op),
      .next_op (next_op)
   );

   op_history u_hist (
      .clk      (clk),
      .rst      (rst),
      .next_op  (next_op),
      .last_op  (hist_op),
      .rd_issue (rd_issue),
      .wr_issue (wr_issue)
   );

   assign last_op = hist_op;

   // R3
   both_idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req && wr_req && hist_op == OP_IDLE) |=> rd_issue);

   // R4
   both_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req && wr_req && hist_op == OP_RD) |=> wr_issue);

   // R5
   both_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req && wr_req && hist_op == OP_WR) |=> rd_issue);

   // R7
   lone_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_req && wr_req && hist_op != OP_WR) |=> (wr_issue && !rd_issue));

   // R9
   none_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_req && !wr_req) |=> (last_op == 2'b00 && !rd_issue && !wr_issue));
endmodule

// File: tb/test_rw_slot_arbiter.sv
module test_rw_slot_arbiter;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rd_sel_n = 1'b1;
   logic wr_sel_n = 1'b1;
   logic rd_issue, wr_issue;
   logic [1:0] last_op;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rw_slot_arbiter i_rw_slot_arbiter (
      .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
      .rd_issue(rd_issue), .wr_issue(wr_issue), .last_op(last_op)
   );

   // vector: prev(2) 0 idle,1 read,2 write | rd_sel_n | wr_sel_n | exp_rd | exp_wr
   localparam logic [5:0] VEC [12] = '{
      {2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
      {2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
      {2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
      {2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
      {2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
      {2'd1, 1'b0, 1'b1, 1'b0, 1'b0},
      {2'd1, 1'b1, 1'b0, 1'b0, 1'b1},
      {2'd1, 1'b0, 1'b0, 1'b0, 1'b1},
      {2'd2, 1'b1, 1'b1, 1'b0, 1'b0},
      {2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
      {2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
      {2'd2, 1'b0, 1'b0, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {rd,wr,last}=%b expected %b", req, act, exp);
      end
   endtask

   task automatic apply(input logic rn, input logic wn);
      rd_sel_n = rn;
      wr_sel_n = wn;
      @(negedge clk);
   endtask

   function automatic logic [3:0] pack(input logic r, input logic w);
      return {r, w, w, r};
   endfunction

   initial begin
      @(negedge clk);
      rd_sel_n = 1'b0; wr_sel_n = 1'b0;
      @(negedge clk);
      // R11 reset with both selects active
      chk("R11", {rd_issue, wr_issue, last_op}, 4'b0000);
      rst = 1'b0;

      // R3 R4 R5 R7 R8 R9 R10 table walk
      foreach (VEC[i]) begin
         apply(1'b1, 1'b1);
         if (VEC[i][5:4] == 2'd1) apply(1'b0, 1'b1);
         if (VEC[i][5:4] == 2'd2) apply(1'b1, 1'b0);
         apply(VEC[i][3], VEC[i][2]);
         chk("R3/R4/R5/R7/R8/R9/R10", {rd_issue, wr_issue, last_op},
             pack(VEC[i][1], VEC[i][0]));
      end

      // R6 alternation from idle
      apply(1'b1, 1'b1);
      for (int k = 0; k < 6; k++) begin
         apply(1'b0, 1'b0);
         chk("R6", {rd_issue, wr_issue, last_op}, (k % 2 == 0) ? pack(1, 0) : pack(0, 1));
      end

      // R8 lone read: issue, stall, issue
      apply(1'b1, 1'b1);
      apply(1'b0, 1'b1);
      chk("R8", {rd_issue, wr_issue, last_op}, pack(1, 0));
      apply(1'b0, 1'b1);
      chk("R8", {rd_issue, wr_issue, last_op}, pack(0, 0));
      apply(1'b0, 1'b1);
      chk("R8", {rd_issue, wr_issue, last_op}, pack(1, 0));

      // R2 pulse between edges is ignored
      apply(1'b1, 1'b1);
      rd_sel_n = 1'b0; wr_sel_n = 1'b0;
      #2;
      rd_sel_n = 1'b1; wr_sel_n = 1'b1;
      @(negedge clk);
      chk("R2", {rd_issue, wr_issue, last_op}, pack(0, 0));

      // R2 strobe holds after select drops mid-cycle
      rd_sel_n = 1'b1; wr_sel_n = 1'b0;
      @(posedge clk);
      #1;
      wr_sel_n = 1'b1;
      @(negedge clk);
      chk("R2", {rd_issue, wr_issue, last_op}, pack(0, 1));

      // R11 mid-run reset
      apply(1'b0, 1'b1);
      rst = 1'b1;
      apply(1'b0, 1'b0);
      chk("R11", {rd_issue, wr_issue, last_op}, 4'b0000);
      rst = 1'b0;
      apply(1'b0, 1'b0);
      chk("R11", {rd_issue, wr_issue, last_op}, pack(1, 0));

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: done=0 expected 1");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule